// File: doc/BRIEF.md
# Write-One-to-Clear Interrupt Aggregator

This block gathers the event sources of a USB host controller into one interrupt line. Eight event positions are latched in a status word: seven ordinary events in bits 0 to 6 and an ownership-change event in bit 30. Each event arrives as a one-cycle pulse on its own bit of an input vector and sets its status bit until software clears it. Software clears a status bit by writing a one to that bit.

The enables live in a single mask register. The mask has no plain write path. One address sets every mask bit written as one. A second address clears every mask bit written as one. Both addresses read back the same mask. Bit 31 of the mask is a global gate. The interrupt line is high only when that gate is open and at least one latched event has its own enable set.

The register bus is a simple strobe interface. A write takes effect on the clock edge where the strobe is high. Read data follows the address combinationally.

Top module: `irq_w1c_ctrl`

## Requirements
- R1: After reset, the status word and the mask are all zero, every address reads zero, and `irq` is low.
- R2: A pulse on `evt_pulse` bit 0, 1, 2, 3, 4, 5, 6 or 30 sets the same status bit on that clock edge. The bit stays set until software clears it.
- R3: A write to address 0 clears each status bit written as one and leaves each bit written as zero unchanged.
- R4: A write to address 1 sets each implemented mask bit written as one. Zeros written have no effect.
- R5: A write to address 2 clears each mask bit written as one. Zeros written have no effect.
- R6: Address 0 reads the status word. Addresses 1 and 2 both read the current mask. Address 3 reads zero.
- R7: `irq` is high exactly when mask bit 31 is set and some status bit is set whose mask bit is also set.
- R8: When an event pulse and a clearing write hit the same status bit on the same edge, the bit ends up set.
- R9: Status bits 7 to 29 and 31, and mask bits 7 to 29, always read zero. Events and writes to them are ignored.
- R10: Mask bit 31 is the master enable. It is set and cleared through addresses 1 and 2 like the other mask bits. While it is clear, `irq` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset. Release is synchronised internally over two edges. |
| evt_pulse | input | 32 | One-cycle event pulses, one per status bit |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 2 | Register select: 0 status, 1 enable-set, 2 enable-clear |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq | output | 1 | Aggregated interrupt request |

## Verification
Single-bit events are applied at every implemented position and then at every reserved position. A mix of events is then cleared by a write that has ones only on some bits, which shows whether a clear touches just the bits written as one. The mask is built up and torn down through the set and clear addresses with mixed patterns, and read back at both addresses, which separates the two write actions from each other and from a plain write. The interrupt line is checked with the master enable open and closed, with a matching enable and with a non-matching one. One cycle places an event and a clear of the same bit on the same edge, to confirm that the event takes priority.

// File: rtl/irq_w1c_pkg.sv
package irq_w1c_pkg;

  typedef enum logic [1:0] {
    REG_STATUS = 2'd0,
    REG_ENSET  = 2'd1,
    REG_ENCLR  = 2'd2,
    REG_NONE   = 2'd3
  } reg_sel_e;

  // implemented event positions: bits 0..6 and 30
  localparam logic [31:0] DEF_EVT_BITS = 32'h4000_007F;
  localparam int          DEF_MASTER   = 31;

endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_q_n = sync_q[1];

endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg #(
  parameter int              DW   = 32,
  parameter logic [DW-1:0]   IMPL = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] set_vec,
  input  logic [DW-1:0] clr_vec,
  output logic [DW-1:0] stat
);

  logic [DW-1:0] stat_q, stat_d, set_m, clr_m;
  logic          stat_en;

  always_comb begin
    set_m   = set_vec & IMPL;
    clr_m   = clr_vec & IMPL;
    stat_en = |(set_m | clr_m);
    // a set on the same edge as a clear wins
    stat_d  = set_m | (stat_q & ~clr_m);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       stat_q <= '0;
    else if (stat_en) stat_q <= stat_d;
  end

  assign stat = stat_q;

  a_r8_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|(set_vec & IMPL)) |=> ((stat & $past(set_vec & IMPL)) == $past(set_vec & IMPL)));

  a_r3_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_vec & ~set_vec)) |=> ((stat & $past(clr_vec & ~set_vec)) == '0));

  a_r9_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (stat & ~IMPL) == '0);

endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int              DW   = 32,
  parameter logic [DW-1:0]   IMPL = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_wr,
  input  logic          clr_wr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] mask
);

  logic [DW-1:0] mask_q, mask_d, wd_m;
  logic          mask_en;

  always_comb begin
    wd_m    = wdata & IMPL;
    mask_en = set_wr | clr_wr;
    mask_d  = mask_q;
    if (set_wr) mask_d = mask_d | wd_m;
    if (clr_wr) mask_d = mask_d & ~wd_m;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_en) mask_q <= mask_d;
  end

  assign mask = mask_q;

  a_r4_set_bits: assert property (@(posedge clk) disable iff (!rst_n)
    set_wr |=> ((mask & $past(wdata & IMPL)) == $past(wdata & IMPL)));

  a_r5_clear_bits: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr |=> ((mask & $past(wdata)) == '0));

  a_r4_zero_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    set_wr |=> ((mask & $past(mask_q)) == $past(mask_q)));

endmodule

// File: rtl/irq_w1c_ctrl.sv
module irq_w1c_ctrl
  import irq_w1c_pkg::*;
#(
  parameter int            DW       = 32,
  parameter logic [DW-1:0] EVT_BITS = DEF_EVT_BITS,
  parameter int            MASTER   = DEF_MASTER
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] evt_pulse,
  input  logic          bus_wr,
  input  logic [1:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq
);

  localparam logic [DW-1:0] MASTER_BIT = {{(DW-1){1'b0}}, 1'b1} << MASTER;
  localparam logic [DW-1:0] MASK_BITS  = EVT_BITS | MASTER_BIT;

  logic          rst_q_n;
  logic          wr_stat, wr_enset, wr_enclr;
  logic [DW-1:0] stat_clr, stat, mask;
  logic          any_hit;
  reg_sel_e      sel;

  irq_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  always_comb begin
    sel      = reg_sel_e'(bus_addr);
    wr_stat  = bus_wr && (sel == REG_STATUS);
    wr_enset = bus_wr && (sel == REG_ENSET);
    wr_enclr = bus_wr && (sel == REG_ENCLR);
    stat_clr = wr_stat ? bus_wdata : '0;
  end

  irq_status_reg #(.DW(DW), .IMPL(EVT_BITS)) u_stat (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .set_vec (evt_pulse),
    .clr_vec (stat_clr),
    .stat    (stat)
  );

  irq_mask_reg #(.DW(DW), .IMPL(MASK_BITS)) u_mask (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .set_wr (wr_enset),
    .clr_wr (wr_enclr),
    .wdata  (bus_wdata),
    .mask   (mask)
  );

  always_comb begin
    case (sel)
      REG_STATUS: bus_rdata = stat;
      REG_ENSET,
      REG_ENCLR:  bus_rdata = mask;
      default:    bus_rdata = '0;
    endcase
    any_hit = |(stat & mask & EVT_BITS);
    irq     = mask[MASTER] & any_hit;
  end

  a_r10_master_gate: assert property (@(posedge clk) disable iff (!rst_q_n)
    !mask[MASTER] |-> !irq);

  a_r7_needs_event: assert property (@(posedge clk) disable iff (!rst_q_n)
    irq |-> (stat != '0));

  a_r6_alias_read: assert property (@(posedge clk) disable iff (!rst_q_n)
    (sel == REG_ENCLR) |-> (bus_rdata == mask));

endmodule

// File: tb/sim_irq_w1c_ctrl.sv
module sim_irq_w1c_ctrl;

  localparam logic [31:0] EVB = 32'h4000_007F;
  localparam logic [31:0] MKB = 32'hC000_007F;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] evt_pulse = '0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int total = 0;
  int bad = 0;
  string req = "R1";
  logic [31:0] m_st = '0;
  logic [31:0] m_mk = '0;

  always #10 clk = ~clk;

  irq_w1c_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic step(input logic wr, input logic [1:0] a,
                      input logic [31:0] wd, input logic [31:0] ev);
    logic [31:0] exp_rd;
    logic        exp_irq;
    @(negedge clk);
    bus_wr = wr; bus_addr = a; bus_wdata = wd; evt_pulse = ev;
    #1;
    case (a)
      2'd0:    exp_rd = m_st;
      2'd1,
      2'd2:    exp_rd = m_mk;
      default: exp_rd = '0;
    endcase
    exp_irq = m_mk[31] && ((m_st & m_mk & EVB) != 0);
    total++;
    if (bus_rdata !== exp_rd) begin
      bad++;
      $display("FAIL %s rdata addr=%0d actual=%h expected=%h", req, a, bus_rdata, exp_rd);
    end
    total++;
    if (irq !== exp_irq) begin
      bad++;
      $display("FAIL %s irq actual=%b expected=%b", req, irq, exp_irq);
    end
    @(posedge clk);
    if (rst_n) begin
      if (wr && a == 2'd0) m_st = m_st & ~wd;
      m_st = m_st | (ev & EVB);
      if (wr && a == 2'd1) m_mk = m_mk | (wd & MKB);
      if (wr && a == 2'd2) m_mk = m_mk & ~(wd & MKB);
    end
  endtask

  task automatic rd(input logic [1:0] a);
    step(1'b0, a, 32'h0, 32'h0);
  endtask

  initial begin
    #200000;
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1: reset state, including the synchroniser delay after release
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < 4; k++) rd(2'(k));
    rd(2'd0);

    // R2: each implemented event position
    req = "R2";
    for (int b = 0; b < 7; b++) begin step(1'b0, 2'd3, 0, 32'h1 << b); rd(2'd0); end
    step(1'b0, 2'd3, 0, 32'h4000_0000);
    rd(2'd0); rd(2'd0);

    // R3: clear a subset, zeros leave other bits
    req = "R3";
    step(1'b1, 2'd0, 32'h0000_0015, 0);
    rd(2'd0);
    step(1'b1, 2'd0, 32'h0, 0);
    rd(2'd0);
    step(1'b1, 2'd0, 32'hFFFF_FFFF, 0);
    rd(2'd0);

    // R9: reserved positions ignore events and writes
    req = "R9";
    for (int b = 7; b < 30; b++) step(1'b0, 2'd0, 0, 32'h1 << b);
    step(1'b0, 2'd0, 0, 32'h8000_0000);
    rd(2'd0);
    step(1'b1, 2'd1, 32'h3FFF_FF80, 0);
    rd(2'd1); rd(2'd2);

    // R4: set mask bits through address 1, zeros keep bits
    req = "R4";
    step(1'b1, 2'd1, 32'h0000_0005, 0);
    rd(2'd1);
    step(1'b1, 2'd1, 32'h0000_0042, 0);
    rd(2'd1);

    // R6: both mask addresses and the spare address
    req = "R6";
    rd(2'd2); rd(2'd3); rd(2'd0);

    // R5: clear mask bits through address 2
    req = "R5";
    step(1'b1, 2'd2, 32'h0000_0004, 0);
    rd(2'd1);
    step(1'b1, 2'd2, 32'h0, 0);
    rd(2'd2);

    // R10: events pending with enables but no master: irq low
    req = "R10";
    step(1'b0, 2'd3, 0, 32'h0000_0003);
    rd(2'd0); rd(2'd1);
    step(1'b1, 2'd1, 32'h8000_0000, 0);
    rd(2'd1);

    // R7: irq follows matching enables
    req = "R7";
    step(1'b1, 2'd0, 32'h0000_0003, 0);
    rd(2'd0);
    step(1'b0, 2'd3, 0, 32'h0000_0008);
    rd(2'd0);
    step(1'b0, 2'd3, 0, 32'h0000_0040);
    rd(2'd0);
    step(1'b1, 2'd1, 32'h4000_0000, 0);
    step(1'b0, 2'd3, 0, 32'h4000_0000);
    rd(2'd0);
    step(1'b1, 2'd2, 32'h8000_0000, 0);
    rd(2'd2);
    step(1'b1, 2'd1, 32'h8000_0000, 0);
    rd(2'd0);

    // R8: event and clear of the same bit on one edge
    req = "R8";
    step(1'b1, 2'd0, 32'hFFFF_FFFF, 32'h0000_0001);
    rd(2'd0);
    step(1'b1, 2'd0, 32'h0000_0011, 32'h0000_0010);
    rd(2'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule